// File: doc/BRIEF.md
# Predicated Vector Float-to-Integer Converter

The block takes one 128-bit vector of floating-point lanes and converts every lane to an integer of the same width. There are two lane formats: eight half-precision lanes or four single-precision lanes. Each operation also selects a signed or unsigned result and one of four rounding directions. The rounding direction travels with the operation. The block holds no rounding state between operations, so any setting kept elsewhere for other arithmetic is never touched.

A 16-bit byte mask predicates the write-back. A destination byte whose mask bit is clear keeps the value from the previous destination vector, which the caller supplies. A lane whose lowest byte is masked off still merges its enabled bytes, but it adds nothing to the exception flags. The two flags are the OR over all lanes that contribute. Operations enter through a valid/ready handshake and leave one register stage later through a second valid/ready pair. Operations whose size code is undefined are accepted and marked as undefined, and the old destination comes back unchanged.

Top module: `fpcvt_top`

## Requirements
- R1: `in_size` = 1 selects eight 16-bit half-precision lanes, and `in_size` = 2 selects four 32-bit single-precision lanes. Lane k occupies bits [W*k+W-1 : W*k], where W is the lane width. Each result has the width of its lane, and `out_undef` is 0.
- R2: `in_size` = 0 or 3 is undefined. The operation is still accepted, and it returns `out_undef` = 1, `out_flags` = 0 and `out_dest` equal to `in_old`.
- R3: `in_rmode` encodes the rounding: 0 is nearest with ties away from zero, 1 is nearest with ties to even, 2 is toward plus infinity, 3 is toward minus infinity.
- R4: `in_uns` = 0 gives a two's-complement signed result, and `in_uns` = 1 gives an unsigned result. A negative input whose rounded value is below 0 saturates to 0 when the result is unsigned.
- R5: Mask bit j governs byte j, bits [8j+7:8j], of the vector. `out_dest` byte j is the converted byte where bit j is 1 and the `in_old` byte where it is 0.
- R6: A lane with all of its mask bits at 0 leaves its bytes equal to `in_old` and contributes no flags.
- R7: A lane adds its flags only when the mask bit of its lowest byte (bit 2k for half lanes, bit 4k for single lanes) is 1. Otherwise its enabled bytes still merge.
- R8: NaN converts to 0. Infinities and rounded values outside the result range saturate to the type's maximum or minimum. Each of these cases raises Invalid.
- R9: Inexact is raised when non-zero fraction bits are discarded, but never in a lane that raised Invalid.
- R10: Subnormal inputs are rounded like any other value and give 0 or ±1 according to the direction.
- R11: `in_ready` is high whenever the output register is empty or is being drained. An accepted operation appears on the outputs on the next cycle. While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady. After reset, `out_valid` is 0.
- R12: `out_flags[1]` is Invalid and `out_flags[0]` is Inexact, each the OR over the contributing lanes.
- R13: Back-to-back operations with different rounding fields each round only by their own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_size | input | 2 | Lane size code (1 half, 2 single) |
| in_uns | input | 1 | Unsigned result when 1 |
| in_rmode | input | 2 | Rounding direction |
| in_src | input | 128 | Source float vector |
| in_old | input | 128 | Previous destination vector |
| in_mask | input | 16 | Byte write mask |
| out_valid | output | 1 | Result held on outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | 128 | Merged destination |
| out_flags | output | 2 | {Invalid, Inexact} |
| out_undef | output | 1 | Operation had an undefined size |

## Verification
In a single lane, the byte merge and the flag gating act on the same operation. A lane whose lowest byte is masked off, while its upper bytes are enabled and its value saturates or rounds, must write those upper bytes and still leave both flags clear. The bench provokes this with alternating-byte masks over NaN, infinite and fractional inputs, and judges each byte and each flag bit against a behavioural model based on real numbers. In a second case, a new operation is accepted in the same cycle that a stalled result drains. Randomised back-pressure provokes this, and the in-order queue of expected results judges it.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  typedef enum logic [1:0] {
    RND_AWAY = 2'd0,
    RND_EVEN = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rnd_e;

  localparam logic [1:0] SZ_HALF   = 2'd1;
  localparam logic [1:0] SZ_SINGLE = 2'd2;

  typedef struct packed {
    logic [31:0] val;
    logic        inv;
    logic        inx;
  } cvt_res_t;

  // Convert one half (half=1, value in b[15:0]) or single float to integer.
  function automatic cvt_res_t fp_cvt(input logic [31:0] b, input logic half,
                                      input logic uns, input logic [1:0] rm);
    logic              s;
    logic [7:0]        eb;
    logic [7:0]        emax;
    logic [22:0]       f;
    logic [23:0]       m;
    logic signed [9:0] ex;
    logic [9:0]        sh;
    logic [95:0]       x;
    logic [63:0]       ip, mag, lim_p, lim_n;
    logic              g, st, inc, big, ovf, nan_in, inf_in;
    logic [31:0]       sat, sval;
    cvt_res_t          r;
    if (half) begin
      s    = b[15];
      eb   = {3'b000, b[14:10]};
      f    = {b[9:0], 13'b0};
      emax = 8'd31;
      ex   = $signed({2'b00, (eb == 8'd0) ? 8'd1 : eb}) - 10'sd15;
    end else begin
      s    = b[31];
      eb   = b[30:23];
      f    = b[22:0];
      emax = 8'd255;
      ex   = $signed({2'b00, (eb == 8'd0) ? 8'd1 : eb}) - 10'sd127;
    end
    m      = {(eb != 8'd0), f};
    nan_in = (eb == emax) && (f != 23'd0);
    inf_in = (eb == emax) && (f == 23'd0);
    big    = ex >= 10'sd33;
    x      = {40'b0, m, 32'b0};
    sh     = 10'd0;
    if (ex >= 10'sd23) begin
      sh = 10'(ex - 10'sd23);
      x  = x << sh;
    end else if (ex >= -10'sd9) begin
      sh = 10'(10'sd23 - ex);
      x  = x >> sh;
    end else begin
      x  = {95'b0, (m != 24'd0)};
    end
    ip = x[95:32];
    g  = x[31];
    st = |x[30:0];
    case (rnd_e'(rm))
      RND_AWAY: inc = g;
      RND_EVEN: inc = g & (st | ip[0]);
      RND_UP:   inc = ~s & (g | st);
      default:  inc = s & (g | st);
    endcase
    mag   = ip + {63'b0, inc};
    lim_p = half ? (uns ? 64'hFFFF : 64'h7FFF) : (uns ? 64'hFFFF_FFFF : 64'h7FFF_FFFF);
    lim_n = uns ? 64'd0 : (half ? 64'h8000 : 64'h8000_0000);
    ovf   = big || (s ? (mag > lim_n) : (mag > lim_p));
    if (s) sat = uns ? 32'd0 : (half ? 32'h0000_8000 : 32'h8000_0000);
    else   sat = lim_p[31:0];
    sval = s ? (32'd0 - mag[31:0]) : mag[31:0];
    if (nan_in) begin
      r.val = 32'd0; r.inv = 1'b1; r.inx = 1'b0;
    end else if (inf_in || ovf) begin
      r.val = sat;   r.inv = 1'b1; r.inx = 1'b0;
    end else begin
      r.val = half ? {16'd0, sval[15:0]} : sval;
      r.inv = 1'b0;
      r.inx = g | st;
    end
    return r;
  endfunction

endpackage

// File: rtl/fpcvt_lane.sv
module fpcvt_lane
  import fpcvt_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [EW-1:0] src,
  input  logic          uns,
  input  logic [1:0]    rm,
  output logic [EW-1:0] val,
  output logic          inv,
  output logic          inx
);
  localparam logic IS_HALF = (EW == 16);

  cvt_res_t res;

  always_comb begin
    res = fp_cvt(32'(src), IS_HALF, uns, rm);
    val = res.val[EW-1:0];
    inv = res.inv;
    inx = res.inx;
  end

  generate
    if (EW < 32) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^res.val[31:EW];
    end
  endgenerate
endmodule

// File: rtl/fpcvt_merge.sv
module fpcvt_merge #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] conv,
  input  logic [8*NB-1:0] old,
  input  logic [NB-1:0]   mask,
  input  logic [NB-1:0]   inv_b,
  input  logic [NB-1:0]   inx_b,
  input  logic            size_ok,
  output logic [8*NB-1:0] dest,
  output logic [1:0]      flags,
  output logic [NB-1:0]   flag_gate
);
  genvar j;
  generate
    for (j = 0; j < NB; j++) begin : g_byte
      assign dest[8*j +: 8] = (size_ok && mask[j]) ? conv[8*j +: 8] : old[8*j +: 8];
    end
  endgenerate

  // inv_b/inx_b are non-zero only on the lowest byte of a lane
  assign flag_gate = size_ok ? mask : '0;
  assign flags     = {|(inv_b & flag_gate), |(inx_b & flag_gate)};
endmodule

// File: rtl/fpcvt_top.sv
module fpcvt_top
  import fpcvt_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_size,
  input  logic               in_uns,
  input  logic [1:0]         in_rmode,
  input  logic [VEC_W-1:0]   in_src,
  input  logic [VEC_W-1:0]   in_old,
  input  logic [VEC_W/8-1:0] in_mask,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_dest,
  output logic [1:0]         out_flags,
  output logic               out_undef
);
  localparam int NB = VEC_W / 8;
  localparam int NH = VEC_W / 16;
  localparam int NS = VEC_W / 32;

  logic             acc, size_ok, half_sel;
  logic [VEC_W-1:0] h_val, s_val, conv, m_dest;
  logic [NH-1:0]    h_inv, h_inx;
  logic [NS-1:0]    s_inv, s_inx;
  logic [NB-1:0]    inv_b, inx_b, flag_gate;
  logic [1:0]       m_flags;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign half_sel = (in_size == SZ_HALF);
  assign size_ok  = half_sel || (in_size == SZ_SINGLE);

  genvar i;
  generate
    for (i = 0; i < NH; i++) begin : g_half
      fpcvt_lane #(.EW(16)) u_lane (
        .src(in_src[16*i +: 16]), .uns(in_uns), .rm(in_rmode),
        .val(h_val[16*i +: 16]), .inv(h_inv[i]), .inx(h_inx[i]));
    end
    for (i = 0; i < NS; i++) begin : g_single
      fpcvt_lane #(.EW(32)) u_lane (
        .src(in_src[32*i +: 32]), .uns(in_uns), .rm(in_rmode),
        .val(s_val[32*i +: 32]), .inv(s_inv[i]), .inx(s_inx[i]));
    end
    for (i = 0; i < NB; i++) begin : g_fbyte
      if (i % 4 == 0) begin : g_l4
        assign inv_b[i] = half_sel ? h_inv[i/2] : s_inv[i/4];
        assign inx_b[i] = half_sel ? h_inx[i/2] : s_inx[i/4];
      end else if (i % 2 == 0) begin : g_l2
        assign inv_b[i] = half_sel & h_inv[i/2];
        assign inx_b[i] = half_sel & h_inx[i/2];
      end else begin : g_l0
        assign inv_b[i] = 1'b0;
        assign inx_b[i] = 1'b0;
      end
    end
  endgenerate

  assign conv = half_sel ? h_val : s_val;

  fpcvt_merge #(.NB(NB)) u_merge (
    .conv(conv), .old(in_old), .mask(in_mask), .inv_b(inv_b), .inx_b(inx_b),
    .size_ok(size_ok), .dest(m_dest), .flags(m_flags), .flag_gate(flag_gate));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dest  <= '0;
      out_flags <= '0;
      out_undef <= 1'b0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_dest  <= m_dest;
      out_flags <= m_flags;
      out_undef <= !size_ok;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fpcvt_chk.sv
module fpcvt_chk #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc,
  input logic [1:0]         in_size,
  input logic [VEC_W-1:0]   in_old,
  input logic [VEC_W/8-1:0] in_mask,
  input logic               out_valid,
  input logic               out_ready,
  input logic [VEC_W-1:0]   out_dest,
  input logic [1:0]         out_flags,
  input logic               out_undef
);
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_dest) && $stable(out_flags) && $stable(out_undef)));

  assert_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_size == 2'd0 || in_size == 2'd3)) |=>
      (out_undef && out_flags == 2'b00 && out_dest == $past(in_old)));

  assert_defined_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_size == 2'd1 || in_size == 2'd2)) |=> !out_undef);

  assert_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mask == '0) |=> (out_dest == $past(in_old) && out_flags == 2'b00));

  assert_gate_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_size == 2'd1 && (in_mask & 16'h5555) == 16'h0) |=> out_flags == 2'b00);

  assert_gate_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_size == 2'd2 && (in_mask & 16'h1111) == 16'h0) |=> out_flags == 2'b00);
endmodule

bind fpcvt_top fpcvt_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .in_size(in_size), .in_old(in_old),
  .in_mask(in_mask), .out_valid(out_valid), .out_ready(out_ready),
  .out_dest(out_dest), .out_flags(out_flags), .out_undef(out_undef));

// File: tb/sim_fpcvt_top.sv
module sim_fpcvt_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [1:0]   in_size = 2'd1;
  logic         in_uns = 1'b0;
  logic [1:0]   in_rmode = 2'd0;
  logic [127:0] in_src = '0, in_old = '0;
  logic [15:0]  in_mask = '0;
  logic         out_valid, out_ready = 1'b1;
  logic [127:0] out_dest;
  logic [1:0]   out_flags;
  logic         out_undef;

  int  n_checks = 0, n_errors = 0;
  bit  stall_en = 0, done = 0;
  logic [130:0] exp_q[$];
  string        tag_q[$];
  bit           was_held = 0;
  logic [127:0] held_dest;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcvt_top u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Behavioural reference: decode to real, round with floor/ceil, clamp.
  function automatic logic [33:0] ref_cvt(input logic [31:0] b, input bit half,
                                          input bit uns, input logic [1:0] rm);
    int e, f, w; bit s, nan, inf, inv; real v, fl, fr, r, hi, lo; longint li;
    logic [31:0] val;
    w = half ? 16 : 32;
    if (half) begin
      s = b[15]; e = int'(b[14:10]); f = int'(b[9:0]);
      nan = (e == 31) && (f != 0); inf = (e == 31) && (f == 0);
      v = (e == 0) ? real'(f) * (2.0 ** (-24)) : real'(f + 1024) * (2.0 ** (e - 25));
    end else begin
      s = b[31]; e = int'(b[30:23]); f = int'(b[22:0]);
      nan = (e == 255) && (f != 0); inf = (e == 255) && (f == 0);
      v = (e == 0) ? real'(f) * (2.0 ** (-149)) : real'(f + 8388608) * (2.0 ** (e - 150));
    end
    if (s) v = -v;
    hi = uns ? (2.0 ** w) - 1.0 : (2.0 ** (w - 1)) - 1.0;
    lo = uns ? 0.0 : -(2.0 ** (w - 1));
    if (nan) return {1'b1, 1'b0, 32'd0};
    inv = 0; fr = 0.0;
    if (inf) begin
      r = s ? lo : hi; inv = 1;
    end else begin
      fl = $floor(v); fr = v - fl;
      case (rm)
        2'd0: r = (fr > 0.5 || (fr == 0.5 && v > 0.0)) ? fl + 1.0 : fl;
        2'd1: r = (fr > 0.5) ? fl + 1.0 :
                  (fr < 0.5) ? fl : (($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0);
        2'd2: r = $ceil(v);
        default: r = fl;
      endcase
      if (r > hi) begin r = hi; inv = 1; end
      else if (r < lo) begin r = lo; inv = 1; end
    end
    li = longint'(r);
    val = li[31:0];
    if (half) val[31:16] = 16'd0;
    return {inv, (!inv && fr != 0.0), val};
  endfunction

  function automatic logic [130:0] model(input logic [1:0] sz, input bit uns,
      input logic [1:0] rm, input logic [127:0] src, input logic [127:0] old,
      input logic [15:0] mask);
    logic [127:0] conv, d; logic [1:0] fl; logic [33:0] q;
    conv = '0; fl = 2'b00;
    if (sz != 2'd1 && sz != 2'd2) return {old, 2'b00, 1'b1};
    for (int k = 0; k < ((sz == 2'd1) ? 8 : 4); k++) begin
      if (sz == 2'd1) begin
        q = ref_cvt({16'd0, src[16*k +: 16]}, 1, uns, rm);
        conv[16*k +: 16] = q[15:0];
        if (mask[2*k]) fl = fl | q[33:32];
      end else begin
        q = ref_cvt(src[32*k +: 32], 0, uns, rm);
        conv[32*k +: 32] = q[31:0];
        if (mask[4*k]) fl = fl | q[33:32];
      end
    end
    for (int j = 0; j < 16; j++) d[8*j +: 8] = mask[j] ? conv[8*j +: 8] : old[8*j +: 8];
    return {d, fl, 1'b0};
  endfunction

  // One clock: called at a negative edge with inputs already set.
  task automatic step(output bit took);
    logic [130:0] e; string t;
    out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (was_held) check(out_valid && out_dest == held_dest, "R11 hold", out_dest, held_dest);
    was_held = out_valid && !out_ready;
    held_dest = out_dest;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R11 spurious output", 128'(out_valid), 128'd0);
      else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(out_dest == e[130:3], {t, " dest"}, out_dest, e[130:3]);
        check(out_flags == e[2:1], {t, " flags R12"}, 128'(out_flags), 128'(e[2:1]));
        check(out_undef == e[0], {t, " undef"}, 128'(out_undef), 128'(e[0]));
      end
    end
    took = in_valid && in_ready;
    if (took) begin
      exp_q.push_back(model(in_size, in_uns, in_rmode, in_src, in_old, in_mask));
      tag_q.push_back(t_cur);
    end
    @(negedge clk);
  endtask

  string t_cur;

  task automatic issue(input logic [1:0] sz, input bit uns, input logic [1:0] rm,
                       input logic [127:0] src, input logic [127:0] old,
                       input logic [15:0] mask, input string tag);
    bit took;
    in_size = sz; in_uns = uns; in_rmode = rm; in_src = src; in_old = old;
    in_mask = mask; in_valid = 1'b1; t_cur = tag;
    do step(took); while (!took);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    bit took;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) step(took);
    check(exp_q.size() == 0, "R11 drain", 128'(exp_q.size()), 128'd0);
  endtask

  function automatic logic [127:0] rnd_vec(input bit half);
    logic [127:0] v;
    for (int k = 0; k < 4; k++) v[32*k +: 32] = $urandom;
    for (int k = 0; k < (half ? 8 : 4); k++) if ($urandom % 4 != 0) begin
      if (half) v[16*k +: 16] = {1'($urandom), 5'(11 + $urandom % 9), 10'($urandom)};
      else      v[32*k +: 32] = {1'($urandom), 8'(123 + $urandom % 12), 23'($urandom)};
    end
    return v;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // half lanes (lane0 at bits 15:0): 1.5 2.5 -2.5 0.5 -0.5 -1.5 3.699 min-subnormal
  localparam logic [127:0] HV_TIES = {16'h0001, 16'h4366, 16'hBE00, 16'hB800,
                                      16'h3800, 16'hC100, 16'h4100, 16'h3E00};
  // inf -inf nan 65504 -65504 -0.0 -subnormal 40000
  localparam logic [127:0] HV_SAT = {16'h78E2, 16'h8001, 16'h8000, 16'hFBFF,
                                     16'h7BFF, 16'h7E00, 16'hFC00, 16'h7C00};
  // single lanes: 2.5 -2.5 3e9 -3e9
  localparam logic [127:0] SV_A = {32'hCF32D05E, 32'h4F32D05E, 32'hC0200000, 32'h40200000};
  // 2^31 -2^31 nan min-subnormal
  localparam logic [127:0] SV_B = {32'h00000001, 32'h7FC00000, 32'hCF000000, 32'h4F000000};
  // 1e20 -0.3 0.5 -inf
  localparam logic [127:0] SV_C = {32'hFF800000, 32'h3F000000, 32'hBE99999A, 32'h60AD78EC};

  initial begin : main
    bit took;
    logic [127:0] old;
    old = 128'hA5A5_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    check(!out_valid && in_ready, "R11 reset", 128'({out_valid, in_ready}), 128'(2'b01));
    @(negedge clk);
    for (int rm = 0; rm < 4; rm++)
      for (int u = 0; u < 2; u++) begin
        issue(2'd1, 1'(u), 2'(rm), HV_TIES, old, 16'hFFFF, "R3 R4 R10 half rounding");
        issue(2'd1, 1'(u), 2'(rm), HV_SAT, old, 16'hFFFF, "R8 R9 half saturation");
        issue(2'd2, 1'(u), 2'(rm), SV_A, old, 16'hFFFF, "R1 R3 single");
        issue(2'd2, 1'(u), 2'(rm), SV_B, old, 16'hFFFF, "R8 R10 single limits");
        issue(2'd2, 1'(u), 2'(rm), SV_C, old, 16'hFFFF, "R4 R9 single mix");
      end
    issue(2'd1, 0, 2'd0, HV_SAT, old, 16'hAAAA, "R5 R7 half upper bytes only");
    issue(2'd2, 1, 2'd1, SV_C, old, 16'hEEEE, "R5 R7 single low byte off");
    issue(2'd2, 0, 2'd2, SV_B, old, 16'h0000, "R6 empty mask");
    issue(2'd1, 0, 2'd3, HV_SAT, old, 16'h0001, "R7 one byte");
    issue(2'd1, 1, 2'd0, HV_TIES, old, 16'h00F0, "R5 R6 partial");
    issue(2'd0, 0, 2'd0, SV_A, old, 16'hFFFF, "R2 size0");
    issue(2'd3, 1, 2'd2, SV_B, old, 16'hFFFF, "R2 size3");
    drain();
    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      sz = ($urandom % 10 == 0) ? 2'(($urandom % 2) * 3) : 2'(1 + $urandom % 2);
      issue(sz, 1'($urandom), 2'($urandom), rnd_vec(sz == 2'd1),
            {$urandom, $urandom, $urandom, $urandom},
            ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom), "R11 R12 R13 random");
      if ($urandom % 4 == 0) step(took);
    end
    drain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule